// File: doc/BRIEF.md
# Key-Gated Pin Function Protection Unit

This unit keeps the pin-function selection bits of a GPIO port from being changed by a stray write. It holds three registers on the port's register bus: a lock word, a per-pin commit mask and a per-pin function-select word. The commit mask can only be rewritten while the unit is unlocked. Software unlocks the unit by writing one exact 32-bit key to the lock word. Function-select writes land only on the pins whose commit bit is set. Every other pin keeps the value it already had.

The function-select word leaves the unit on `afsel_o` and feeds the pad multiplexer, which is not part of this block. The lock state is also brought out on `locked_o` as a plain status pin.

Commands arrive on a valid-only request channel, with one command per cycle when `cmd_valid_i` is high. The unit has no back-pressure, so every command is taken on the edge where it is presented. A read command produces exactly one response beat on `rsp_valid_o` in the following cycle. The sink must take that beat, because no ready signal exists on the response channel. Register offsets are byte offsets on a word-aligned bus.

Top module: `cfgprot_guard`

## Requirements
- R1: After reset the unit is locked (`locked_o`=1), the commit mask reads 0x000000FF and the function-select word is 0x00.
- R2: A write of exactly 0x0ACCE551 to the lock word (offset 0x520) unlocks the unit. A later read of that offset then returns 0.
- R3: A write of any other value to the lock word locks the unit, including a value one bit away from the key and zero. A read of that offset then returns 1.
- R4: A commit-mask write (offset 0x524) made while unlocked stores the low 8 bits of the data. Bits 31..8 are discarded, and the mask reads back zero-extended.
- R5: A commit-mask write made while locked is dropped, and the mask keeps its previous value.
- R6: A function-select write (offset 0x420) updates only bit positions whose commit bit is 1. Positions with a 0 commit bit keep their old value, and bits 31..8 of the data are ignored.
- R7: A lock-word write takes effect on the edge that accepts it. A commit-mask write in the very next cycle is therefore judged against the new lock state.
- R8: A read command produces `rsp_valid_o`=1 in the next cycle, carrying the register value at the moment of the read. Commit mask and function-select read back the same way whether the unit is locked or not, and unmapped offsets read 0.
- R9: Writes to unmapped offsets change no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 12 | Byte offset of the register |
| cmd_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response beat, one cycle after the read |
| rsp_rdata_o | output | 32 | Read response data, 0 when no beat |
| locked_o | output | 1 | 1 while the unit is locked |
| afsel_o | output | 8 | Function-select bits, one per pin |

## Verification
Two things can meet on one cycle boundary. The first is a lock-state change, and the second is the commit gate judging the command that directly follows it. The bench provokes this with back-to-back commands: the key followed at once by a commit write, and a wrong key followed at once by a commit write. The commit mask is then read back to see whether the gate used the updated lock state. A read issued on the cycle right after a write also meets the new value being registered. Each such response is judged against a behavioural model that is updated on every edge and compared on every clock.

// File: rtl/cfgprot_pkg.sv
package cfgprot_pkg;

  // Which register a command addresses.
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_FUNC   = 2'd1,
    SEL_LOCK   = 2'd2,
    SEL_COMMIT = 2'd3
  } reg_sel_e;

  // Decoded command for one cycle.
  typedef struct packed {
    logic     rd;
    logic     wr;
    reg_sel_e sel;
  } cmd_dec_t;

endpackage

// File: rtl/cfgprot_decode.sv
module cfgprot_decode
  import cfgprot_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] FUNC_OFS   = 12'h420,
  parameter logic [ADDR_W-1:0] LOCK_OFS   = 12'h520,
  parameter logic [ADDR_W-1:0] COMMIT_OFS = 12'h524
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output cmd_dec_t          dec
);

  reg_sel_e sel;

  always_comb begin
    if (addr == FUNC_OFS)        sel = SEL_FUNC;
    else if (addr == LOCK_OFS)   sel = SEL_LOCK;
    else if (addr == COMMIT_OFS) sel = SEL_COMMIT;
    else                         sel = SEL_NONE;
  end

  always_comb begin
    dec.rd  = valid & ~write;
    dec.wr  = valid & write;
    dec.sel = sel;
  end

endmodule

// File: rtl/cfgprot_lock.sv
module cfgprot_lock #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY    = 32'h0ACC_E551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);

  logic key_match;

  // Full-width comparison: a near miss still locks.
  assign key_match = (wdata == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     locked <= 1'b1;
    else if (wr_en) locked <= ~key_match;
  end

endmodule

// File: rtl/cfgprot_commit.sv
module cfgprot_commit #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             locked,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] mask
);

  logic accept;

  // The gate uses the lock state held in the register before this edge.
  assign accept = wr_en & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= {CFG_W{1'b1}};
    else if (accept) mask <= wdata;
  end

endmodule

// File: rtl/cfgprot_funcsel.sv
module cfgprot_funcsel #(
  parameter int             CFG_W   = 8,
  parameter logic [CFG_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] mask,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] sel
);

  // One enable-gated flop per pin; the commit bit qualifies the write.
  for (genvar b = 0; b < CFG_W; b++) begin : g_pin
    logic bit_en;
    assign bit_en = wr_en & mask[b];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel[b] <= RST_VAL[b];
      else if (bit_en) sel[b] <= wdata[b];
    end
  end

endmodule

// File: rtl/cfgprot_guard.sv
module cfgprot_guard
  import cfgprot_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter int                CFG_W      = 8,
  parameter logic [DATA_W-1:0] KEY        = 32'h0ACC_E551,
  parameter logic [ADDR_W-1:0] FUNC_OFS   = 12'h420,
  parameter logic [ADDR_W-1:0] LOCK_OFS   = 12'h520,
  parameter logic [ADDR_W-1:0] COMMIT_OFS = 12'h524
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              locked_o,
  output logic [CFG_W-1:0]  afsel_o
);

  localparam int PAD_W = DATA_W - CFG_W;

  cmd_dec_t          dec;
  logic              locked_q;
  logic [CFG_W-1:0]  commit_q;
  logic [CFG_W-1:0]  afsel_q;
  logic              lock_wr, commit_wr, func_wr;
  logic [DATA_W-1:0] rd_mux;

  cfgprot_decode #(
    .ADDR_W(ADDR_W), .FUNC_OFS(FUNC_OFS),
    .LOCK_OFS(LOCK_OFS), .COMMIT_OFS(COMMIT_OFS)
  ) u_dec (
    .valid(cmd_valid_i), .write(cmd_write_i), .addr(cmd_addr_i), .dec(dec)
  );

  assign lock_wr   = dec.wr && (dec.sel == SEL_LOCK);
  assign commit_wr = dec.wr && (dec.sel == SEL_COMMIT);
  assign func_wr   = dec.wr && (dec.sel == SEL_FUNC);

  cfgprot_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(lock_wr), .wdata(cmd_wdata_i),
    .locked(locked_q)
  );

  cfgprot_commit #(.CFG_W(CFG_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .wr_en(commit_wr), .locked(locked_q),
    .wdata(cmd_wdata_i[CFG_W-1:0]), .mask(commit_q)
  );

  cfgprot_funcsel #(.CFG_W(CFG_W), .RST_VAL('0)) u_func (
    .clk(clk), .rst_n(rst_n), .wr_en(func_wr), .mask(commit_q),
    .wdata(cmd_wdata_i[CFG_W-1:0]), .sel(afsel_q)
  );

  // Readback selection, zero-extended to the bus width.
  always_comb begin
    unique case (dec.sel)
      SEL_FUNC:   rd_mux = {{PAD_W{1'b0}}, afsel_q};
      SEL_COMMIT: rd_mux = {{PAD_W{1'b0}}, commit_q};
      SEL_LOCK:   rd_mux = {{(DATA_W-1){1'b0}}, locked_q};
      default:    rd_mux = '0;
    endcase
  end

  // One response beat in the cycle after each read; data is zero otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= dec.rd;
      rsp_rdata_o <= dec.rd ? rd_mux : '0;
    end
  end

  assign locked_o = locked_q;
  assign afsel_o  = afsel_q;

endmodule

// File: rtl/cfgprot_guard_chk.sv
module cfgprot_guard_chk #(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter int                CFG_W      = 8,
  parameter logic [DATA_W-1:0] KEY        = 32'h0ACC_E551,
  parameter logic [ADDR_W-1:0] FUNC_OFS   = 12'h420,
  parameter logic [ADDR_W-1:0] LOCK_OFS   = 12'h520,
  parameter logic [ADDR_W-1:0] COMMIT_OFS = 12'h524
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              rsp_valid,
  input logic              locked,
  input logic [CFG_W-1:0]  afsel,
  input logic [CFG_W-1:0]  commit_mask
);

  logic wr_lock, wr_commit, wr_func, rd_cmd;
  assign wr_lock   = cmd_valid && cmd_write && (cmd_addr == LOCK_OFS);
  assign wr_commit = cmd_valid && cmd_write && (cmd_addr == COMMIT_OFS);
  assign wr_func   = cmd_valid && cmd_write && (cmd_addr == FUNC_OFS);
  assign rd_cmd    = cmd_valid && !cmd_write;

  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && cmd_wdata == KEY) |=> !locked);

  a_r3_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && cmd_wdata != KEY) |=> locked);

  a_r4_commit_stores_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !locked) |=> (commit_mask == $past(cmd_wdata[CFG_W-1:0])));

  a_r5_locked_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && locked) |=> $stable(commit_mask));

  a_r6_afsel_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_func |=> (((afsel ^ $past(afsel)) & ~$past(commit_mask)) == '0));

  a_r6_afsel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_func |=> $stable(afsel));

  a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> rsp_valid);

  a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd |=> !rsp_valid);

  a_r9_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lock |=> $stable(locked));

endmodule

bind cfgprot_guard cfgprot_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .KEY(KEY),
  .FUNC_OFS(FUNC_OFS), .LOCK_OFS(LOCK_OFS), .COMMIT_OFS(COMMIT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid_i), .cmd_write(cmd_write_i),
  .cmd_addr(cmd_addr_i), .cmd_wdata(cmd_wdata_i), .rsp_valid(rsp_valid_o),
  .locked(locked_o), .afsel(afsel_o), .commit_mask(commit_q)
);

// File: tb/cfgprot_guard_tb_top.sv
module cfgprot_guard_tb_top;

  localparam logic [11:0] A_FUNC   = 12'h420;
  localparam logic [11:0] A_LOCK   = 12'h520;
  localparam logic [11:0] A_COMMIT = 12'h524;
  localparam logic [31:0] KEYV     = 32'h0ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [11:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        locked;
  logic [7:0]  afsel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  // Behavioural reference state.
  bit       m_locked = 1'b1;
  bit [7:0] m_commit = 8'hFF;
  bit [7:0] m_afsel  = 8'h00;
  bit       m_rsp_v  = 1'b0;
  int       m_rsp_d  = 0;

  always #4 clk = ~clk;  // 125 MHz

  cfgprot_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .locked_o(locked), .afsel_o(afsel)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      chk("R2/R3 lock status", locked, m_locked);
      chk("R6 function select", afsel, m_afsel);
      chk("R8 response valid", rsp_valid, m_rsp_v);
      if (m_rsp_v) chk("R8 response data", rsp_rdata, m_rsp_d);
    end
  end

  // One command, then back at the falling edge; the model steps on the edge.
  task automatic do_cmd(bit wr, logic [11:0] a, logic [31:0] d);
    bit [7:0] rv;
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(posedge clk);
    m_rsp_v = !wr;
    if (!wr) begin
      if (a == A_FUNC)        rv = m_afsel;
      else if (a == A_COMMIT) rv = m_commit;
      else if (a == A_LOCK)   rv = {7'b0, m_locked};
      else                    rv = 8'h00;
      m_rsp_d = int'(rv);
    end else begin
      if (a == A_LOCK) m_locked = (d != KEYV);
      else if (a == A_COMMIT && !m_locked) m_commit = d[7:0];
      else if (a == A_FUNC) m_afsel = (m_afsel & ~m_commit) | (d[7:0] & m_commit);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle();
    cmd_valid = 1'b0;
    @(posedge clk);
    m_rsp_v = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    do_cmd(1'b0, a, 32'h0);
    chk(tag, rsp_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 locked after reset", locked, 1);
    chk("R1 function select after reset", afsel, 0);
    chk("R8 no response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;

    rd_chk("R1 commit reset value", A_COMMIT, 32'h0000_00FF);
    rd_chk("R1 lock readback", A_LOCK, 32'h1);

    // R5: commit write dropped while locked
    do_cmd(1'b1, A_COMMIT, 32'h0000_000F);
    rd_chk("R5 commit held while locked", A_COMMIT, 32'h0000_00FF);

    // R6: full mask lets every bit through; upper data ignored
    do_cmd(1'b1, A_FUNC, 32'hFFFF_FFA5);
    chk("R6 full mask write", afsel, 8'hA5);

    // R2 then R7/R4: key then commit on the very next cycle
    do_cmd(1'b1, A_LOCK, KEYV);
    do_cmd(1'b1, A_COMMIT, 32'h1234_5633);
    rd_chk("R7 commit right after unlock", A_COMMIT, 32'h0000_0033);
    rd_chk("R2 lock reads 0 when unlocked", A_LOCK, 32'h0);
    do_cmd(1'b1, A_COMMIT, 32'hABCD_EF3C);
    rd_chk("R4 commit low byte only", A_COMMIT, 32'h0000_003C);

    // R6: partial mask 0x3C
    do_cmd(1'b1, A_FUNC, 32'h0000_0000);
    chk("R6 partial mask clear", afsel, 8'h81);
    do_cmd(1'b1, A_FUNC, 32'h0000_00FF);
    chk("R6 partial mask set", afsel, 8'hBD);

    // R3/R7: near-miss key locks; commit next cycle is dropped
    do_cmd(1'b1, A_LOCK, 32'h0ACC_E550);
    do_cmd(1'b1, A_COMMIT, 32'h0000_00FF);
    rd_chk("R7 commit right after lock dropped", A_COMMIT, 32'h0000_003C);
    rd_chk("R3 near miss locks", A_LOCK, 32'h1);
    rd_chk("R8 function select read while locked", A_FUNC, 32'h0000_00BD);

    // R3: zero also locks
    do_cmd(1'b1, A_LOCK, KEYV);
    do_cmd(1'b1, A_LOCK, 32'h0);
    chk("R3 zero locks", locked, 1);

    // R9: unmapped writes and reads
    do_cmd(1'b1, 12'h100, 32'hFFFF_FFFF);
    do_cmd(1'b1, 12'h528, KEYV);
    chk("R9 unmapped write leaves lock", locked, 1);
    chk("R9 unmapped write leaves function select", afsel, 8'hBD);
    rd_chk("R9 unmapped write leaves commit", A_COMMIT, 32'h0000_003C);
    rd_chk("R8 unmapped read is zero", 12'h524 + 12'h4, 32'h0);

    // R6: zero mask freezes everything
    do_cmd(1'b1, A_LOCK, KEYV);
    do_cmd(1'b1, A_COMMIT, 32'h0);
    do_cmd(1'b1, A_LOCK, 32'h1);
    do_cmd(1'b1, A_FUNC, 32'h0000_0042);
    chk("R6 zero mask freezes", afsel, 8'hBD);
    idle();
    chk("R8 no response when idle", rsp_valid, 0);
    idle();

    finish_run();
  end

  initial begin
    wait (cycles > 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end

endmodule